// File: doc/BRIEF.md
# Serial Conversion Frame Interface

This block is the serial slave front end of a sequenced eight-channel, 12-bit converter. It watches a chip-select, a serial clock and a serial data input from a host, all three brought into the system clock domain through a synchroniser. Each low-going chip-select opens a sixteen-bit frame. During that frame the block shifts out a tagged result word and takes in a command word.

The result word carries a zero, then the channel number of the converted sample, then the 12-bit sample. The command word is either a 12-bit control word or, after a flagged control write, a full 16-bit shadow word for the external sequencer. The block also drives a track/hold strobe for the sampling stage. It keeps the control fields, including the two power-mode bits, and raises a sticky flag when frames start closer together than a programmable interval.

The sample value and its channel number come in from outside. The block only frames, tags and serialises them. Everything is timed from the system clock. One SCLK half period must last at least six system clocks.

The frame sequencer has three states:
- `ST_IDLE`: no frame open, and the output is released.
- `ST_SHIFT`: a frame is in progress.
- `ST_DONE`: all sixteen bits were exchanged, and the block waits for chip-select to rise.

The transitions are:
- IDLE→SHIFT on a chip-select fall (frame start).
- SHIFT→DONE on the sixteenth SCLK rising edge (commit).
- SHIFT→IDLE on an early chip-select rise (abort).
- DONE→IDLE on a chip-select rise (close).

Top module: `conv_frame_if`

## Requirements
- R1: A falling chip-select while idle starts a frame: the output enable goes high and `hold` goes high.
- R2: The output word is sent MSB first. It is a 0, then the 3-bit `sample_chan`, then the 12-bit `sample_data`, both captured at frame start. The first bit is valid before the first SCLK rise. Each later bit follows SCLK falling edges 2 to 16, so the host samples on rising edges.
- R3: `hold` returns low on the 14th SCLK falling edge of the frame.
- R4: Outside shadow frames, a frame's first 12 DIN bits form the control word, sampled on SCLK rising edges. The word is committed on the 16th rising edge only when its first bit (write) is 1. The fields in arrival order are: write, seq, unused, addr[2:0], pm[1:0], shadow, unused, range, coding.
- R5: A complete frame whose write bit is 0 leaves every control field unchanged.
- R6: A committed write with seq=0 and shadow=1 sets `shadow_pending`. The next complete frame stores all 16 DIN bits, first bit as MSB, in `shadow_word`, clears `shadow_pending` and leaves the control fields unchanged.
- R7: If chip-select rises before the 16th SCLK rising edge, the frame is aborted: nothing is committed, `frame_done` stays low, and `hold` and the output enable drop.
- R8: `dout_oe` is low whenever no frame is open (chip-select high).
- R9: `spacing_err` is set when a frame starts fewer than `min_gap` system clocks after the previous frame start, and it then stays set until reset.
- R10: After reset the block is idle with `dout_oe`=0 and `hold`=0. The control fields are 0 except `ctl_pm`=2'b11 (normal mode). `shadow_pending`=0 and `spacing_err`=0.
- R11: `frame_done` pulses for exactly one clock for each complete 16-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from host, idles high |
| din | input | 1 | Serial command data from host |
| sample_data | input | 12 | Conversion result to send |
| sample_chan | input | 3 | Channel the result belongs to |
| min_gap | input | 16 | Minimum frame-start spacing in system clocks |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| hold | output | 1 | Track/hold strobe, 1 = hold |
| ctl_seq | output | 1 | Committed sequence bit |
| ctl_addr | output | 3 | Committed channel address |
| ctl_pm | output | 2 | Committed power-mode bits |
| ctl_shadow | output | 1 | Committed shadow-select bit |
| ctl_range | output | 1 | Committed range bit |
| ctl_coding | output | 1 | Committed coding bit |
| shadow_word | output | 16 | Last captured shadow word |
| shadow_pending | output | 1 | Next complete frame is a shadow frame |
| frame_done | output | 1 | One-clock pulse per complete frame |
| spacing_err | output | 1 | Sticky frame-spacing violation |

## Verification
The hardest state to reach from the ports is a shadow frame. It exists only after a committed control write with seq=0 and shadow=1. In that frame a leading 1 must not be taken as a control write. The stimulus table therefore puts such a write directly before a shadow frame that begins with a 1, and then follows with ordinary writes to show that the pending flag has cleared. Aborted frames are reached by dropping chip-select after ten bits of a write word. A spacing violation is reached by raising `min_gap` above the natural frame length and running two frames back to back.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

    localparam int CTL_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } cfi_state_e;

    typedef struct packed {
        logic       seq;
        logic [2:0] addr;
        logic [1:0] pm;
        logic       shadow;
        logic       range_sel;
        logic       coding;
    } cfi_ctl_t;

    localparam logic [1:0] PM_NORMAL = 2'b11;

    localparam cfi_ctl_t CTL_RESET = '{seq: 1'b0, addr: 3'd0, pm: PM_NORMAL,
                                       shadow: 1'b0, range_sel: 1'b0, coding: 1'b0};

    // first received bit sits at index CTL_W-1
    function automatic logic ctl_write_bit(input logic [CTL_W-1:0] w);
        return w[11];
    endfunction

    function automatic cfi_ctl_t ctl_decode(input logic [CTL_W-1:0] w);
        cfi_ctl_t c;
        c.seq       = w[10];
        c.addr      = w[8:6];
        c.pm        = w[5:4];
        c.shadow    = w[3];
        c.range_sel = w[1];
        c.coding    = w[0];
        return c;
    endfunction

endpackage

// File: rtl/cfi_sync.sv
module cfi_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe[0] <= RST_VAL;
        end else begin
            pipe[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[s] <= RST_VAL;
            end else begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfi_tx_shift.sv
module cfi_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    output logic         ser_out
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= par_in;
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
        end
    end

    assign ser_out = sreg_q[W-1];
endmodule

// File: rtl/cfi_gap_mon.sv
module cfi_gap_mon #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] min_gap,
    output logic             err
);
    localparam logic [GAP_W-1:0] CNT_MAX = '1;

    logic [GAP_W-1:0] since_q;
    logic             seen_q;
    logic             err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (start) begin
                since_q <= GAP_W'(1);
                seen_q  <= 1'b1;
                if (seen_q && (since_q < min_gap)) begin
                    err_q <= 1'b1;
                end
            end else if (since_q != CNT_MAX) begin
                since_q <= since_q + GAP_W'(1);
            end
        end
    end

    assign err = err_q;
endmodule

// File: rtl/conv_frame_if.sv
module conv_frame_if
    import cfi_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int RES_W       = 12,
    parameter int CH_W        = 3,
    parameter int TRACK_EDGE  = 14,
    parameter int GAP_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [RES_W-1:0]  sample_data,
    input  logic [CH_W-1:0]   sample_chan,
    input  logic [GAP_W-1:0]  min_gap,
    output logic              dout,
    output logic              dout_oe,
    output logic              hold,
    output logic              ctl_seq,
    output logic [2:0]        ctl_addr,
    output logic [1:0]        ctl_pm,
    output logic              ctl_shadow,
    output logic              ctl_range,
    output logic              ctl_coding,
    output logic [FRAME_BITS-1:0] shadow_word,
    output logic              shadow_pending,
    output logic              frame_done,
    output logic              spacing_err
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] TRACK_IDX = CNT_W'(TRACK_EDGE - 1);

    // ---------------- input synchronisation and edge detection
    logic [2:0] pins_s;
    logic       cs_s, sclk_s, din_s;
    logic       cs_prev_q, sclk_prev_q;

    cfi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, din}),
        .q     (pins_s)
    );

    assign {cs_s, sclk_s, din_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b1;
        end else begin
            cs_prev_q   <= cs_s;
            sclk_prev_q <= sclk_s;
        end
    end

    logic cs_fall, cs_rise, sclk_rise, sclk_fall;
    assign cs_fall   =  cs_prev_q   & ~cs_s;
    assign cs_rise   = ~cs_prev_q   &  cs_s;
    assign sclk_rise = ~sclk_prev_q &  sclk_s;
    assign sclk_fall =  sclk_prev_q & ~sclk_s;

    // ---------------- frame state machine
    cfi_state_e state_q, state_d;
    logic [CNT_W-1:0] rise_cnt_q, fall_cnt_q;

    logic frame_start, commit_ok;
    assign frame_start = (state_q == ST_IDLE) && cs_fall;
    assign commit_ok   = (state_q == ST_SHIFT) && sclk_rise && !cs_rise
                         && (rise_cnt_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall)   state_d = ST_SHIFT;
            ST_SHIFT: if (cs_rise)   state_d = ST_IDLE;
                      else if (commit_ok) state_d = ST_DONE;
            ST_DONE:  if (cs_rise)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- frame outputs and registers
    logic [FRAME_BITS-1:0] rx_q;
    logic [FRAME_BITS-1:0] rx_word;
    logic [CTL_W-1:0]      ctl_word;
    cfi_ctl_t              ctl_q;
    logic [FRAME_BITS-1:0] shadow_q;
    logic                  pending_q;
    logic                  hold_q;
    logic                  done_q;

    assign rx_word  = {rx_q[FRAME_BITS-2:0], din_s};
    assign ctl_word = rx_word[FRAME_BITS-1 -: CTL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q <= '0;
            fall_cnt_q <= '0;
            rx_q       <= '0;
            ctl_q      <= CTL_RESET;
            shadow_q   <= '0;
            pending_q  <= 1'b0;
            hold_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                rise_cnt_q <= '0;
                fall_cnt_q <= '0;
                rx_q       <= '0;
                hold_q     <= 1'b1;
            end else if (state_q != ST_IDLE) begin
                if (cs_rise) begin
                    hold_q <= 1'b0;
                end else begin
                    if (sclk_fall && (fall_cnt_q != CNT_FULL)) begin
                        fall_cnt_q <= fall_cnt_q + CNT_W'(1);
                        if (fall_cnt_q == TRACK_IDX) begin
                            hold_q <= 1'b0;
                        end
                    end
                    if (sclk_rise && (state_q == ST_SHIFT)) begin
                        rise_cnt_q <= rise_cnt_q + CNT_W'(1);
                        rx_q       <= rx_word;
                    end
                end
            end

            if (commit_ok) begin
                done_q <= 1'b1;
                if (pending_q) begin
                    shadow_q  <= rx_word;
                    pending_q <= 1'b0;
                end else if (ctl_write_bit(ctl_word)) begin
                    ctl_q     <= ctl_decode(ctl_word);
                    pending_q <= !ctl_decode(ctl_word).seq && ctl_decode(ctl_word).shadow;
                end
            end
        end
    end

    // ---------------- result serialiser
    logic tx_shift;
    assign tx_shift = (state_q != ST_IDLE) && !cs_rise && sclk_fall && (fall_cnt_q != '0);

    cfi_tx_shift #(.W(FRAME_BITS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_start),
        .shift   (tx_shift),
        .par_in  ({1'b0, sample_chan, sample_data}),
        .ser_out (dout)
    );

    // ---------------- frame spacing monitor
    cfi_gap_mon #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frame_start),
        .min_gap (min_gap),
        .err     (spacing_err)
    );

    assign dout_oe        = (state_q != ST_IDLE);
    assign hold           = hold_q;
    assign ctl_seq        = ctl_q.seq;
    assign ctl_addr       = ctl_q.addr;
    assign ctl_pm         = ctl_q.pm;
    assign ctl_shadow     = ctl_q.shadow;
    assign ctl_range      = ctl_q.range_sel;
    assign ctl_coding     = ctl_q.coding;
    assign shadow_word    = shadow_q;
    assign shadow_pending = pending_q;
    assign frame_done     = done_q;
endmodule

// File: rtl/cfi_chk.sv
module cfi_chk #(
    parameter int FW = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_fall,
    input logic          commit,
    input logic          pending,
    input logic          hold,
    input logic          dout_oe,
    input logic          spacing_err,
    input logic          frame_done,
    input logic [2:0]    ctl_addr,
    input logic [1:0]    ctl_pm,
    input logic [FW-1:0] shadow_word,
    input logic [CW-1:0] rise_cnt
);
    // R1
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(cs_fall));

    // R4
    ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ctl_addr) && $stable(ctl_pm)));

    // R6
    shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && pending) |=> $stable(shadow_word));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !hold);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spacing_err |=> spacing_err);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11
    done_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> dout_oe);

    // R2
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= CW'(FW));
endmodule

bind conv_frame_if cfi_chk #(.FW(FRAME_BITS), .CW(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall     (frame_start),
    .commit      (commit_ok),
    .pending     (pending_q),
    .hold        (hold),
    .dout_oe     (dout_oe),
    .spacing_err (spacing_err),
    .frame_done  (frame_done),
    .ctl_addr    (ctl_addr),
    .ctl_pm      (ctl_pm),
    .shadow_word (shadow_word),
    .rise_cnt    (rise_cnt_q)
);

// File: tb/conv_frame_if_tb.sv
module conv_frame_if_tb;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic [11:0] sample_data = '0;
    logic [2:0]  sample_chan = '0;
    logic [15:0] min_gap = 16'd50;
    logic dout, dout_oe, hold, ctl_seq, ctl_shadow, ctl_range, ctl_coding;
    logic [2:0] ctl_addr;
    logic [1:0] ctl_pm;
    logic [15:0] shadow_word;
    logic shadow_pending, frame_done, spacing_err;

    always #5 clk = ~clk;

    conv_frame_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_data(sample_data), .sample_chan(sample_chan), .min_gap(min_gap),
        .dout(dout), .dout_oe(dout_oe), .hold(hold), .ctl_seq(ctl_seq),
        .ctl_addr(ctl_addr), .ctl_pm(ctl_pm), .ctl_shadow(ctl_shadow),
        .ctl_range(ctl_range), .ctl_coding(ctl_coding), .shadow_word(shadow_word),
        .shadow_pending(shadow_pending), .frame_done(frame_done),
        .spacing_err(spacing_err)
    );

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    always @(posedge clk) if (frame_done) done_cnt <= done_cnt + 1;

    // model of committed state
    logic       m_seq = 0, m_shd = 0, m_rng = 0, m_cod = 0, m_pend = 0;
    logic [2:0] m_addr = 0;
    logic [1:0] m_pm = 2'b11;
    logic [15:0] m_shadow = 0;

    logic oe_at_start, hold_at_start, hold13, hold14;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] w, input int nbits, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        wait_clk(8);
        oe_at_start = dout_oe;
        hold_at_start = hold;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            din = w[15-i];
            wait_clk(H);
            if (i == 12) hold13 = hold;
            if (i == 13) hold14 = hold;
            got[15-i] = dout;
            sclk = 1'b1;
            wait_clk(H);
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic model_commit(input logic [15:0] w);
        if (m_pend) begin
            m_shadow = w;
            m_pend = 1'b0;
        end else if (w[15]) begin
            m_seq = w[14]; m_addr = w[12:10]; m_pm = w[9:8];
            m_shd = w[7]; m_rng = w[5]; m_cod = w[4];
            m_pend = !w[14] && w[7];
        end
    endtask

    task automatic chk_ctl(input string tag);
        chk({ctl_seq, ctl_addr, ctl_pm, ctl_shadow, ctl_range, ctl_coding} ==
            {m_seq, m_addr, m_pm, m_shd, m_rng, m_cod}, tag,
            {23'd0, ctl_seq, ctl_addr, ctl_pm, ctl_shadow, ctl_range, ctl_coding},
            {23'd0, m_seq, m_addr, m_pm, m_shd, m_rng, m_cod});
    endtask

    // {din word, channel, sample}
    localparam logic [30:0] VEC [6] = '{
        {16'hD7A0, 3'd5, 12'hABC},
        {16'h7FFF, 3'd0, 12'h000},
        {16'h8990, 3'd7, 12'hFFF},
        {16'hA5C3, 3'd2, 12'h5A5},
        {16'h9F00, 3'd1, 12'h800},
        {16'h0000, 3'd6, 12'h001}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        int dc;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R10 reset state
        chk(dout_oe == 0 && hold == 0, "R10 idle outputs", {30'd0, dout_oe, hold}, 32'd0);
        chk(ctl_pm == 2'b11, "R10 pm normal", {30'd0, ctl_pm}, 32'd3);
        chk_ctl("R10 ctl reset");
        chk(shadow_pending == 0 && spacing_err == 0, "R10 flags",
            {30'd0, shadow_pending, spacing_err}, 32'd0);

        for (int k = 0; k < 6; k++) begin
            logic [15:0] w;
            w = VEC[k][30:15];
            sample_chan = VEC[k][14:12];
            sample_data = VEC[k][11:0];
            dc = done_cnt;
            run_frame(w, 16, got);
            model_commit(w);
            chk(oe_at_start == 1 && hold_at_start == 1, "R1 frame start",
                {30'd0, oe_at_start, hold_at_start}, 32'd3);
            chk(got == {1'b0, VEC[k][14:0]}, "R2 output word", {16'd0, got}, {17'd0, VEC[k][14:0]});
            chk(hold13 == 1 && hold14 == 0, "R3 hold release", {30'd0, hold13, hold14}, 32'd2);
            chk_ctl(w[15] ? "R4 ctl commit" : "R5 ctl unchanged");
            chk(shadow_word == m_shadow && shadow_pending == m_pend, "R6 shadow path",
                {15'd0, shadow_pending, shadow_word}, {15'd0, m_pend, m_shadow});
            chk(dout_oe == 0 && hold == 0, "R8 idle after frame", {30'd0, dout_oe, hold}, 32'd0);
            chk(done_cnt == dc + 1, "R11 one done pulse", done_cnt, dc + 1);
            wait_clk(20);
        end
        chk(spacing_err == 0, "R9 no error when spaced", {31'd0, spacing_err}, 32'd0);

        // R7 abort mid write
        dc = done_cnt;
        run_frame(16'hE3F0, 10, got);
        chk_ctl("R7 abort keeps ctl");
        chk(done_cnt == dc, "R7 abort no done", done_cnt, dc);
        chk(dout_oe == 0 && hold == 0, "R7 abort released", {30'd0, dout_oe, hold}, 32'd0);
        chk(shadow_pending == 0, "R7 abort no pending", {31'd0, shadow_pending}, 32'd0);

        // R9 violation
        min_gap = 16'd1000;
        wait_clk(1100);
        run_frame(16'h0000, 16, got);
        chk(spacing_err == 0, "R9 first frame spaced", {31'd0, spacing_err}, 32'd0);
        run_frame(16'h0000, 16, got);
        chk(spacing_err == 1, "R9 close frames flagged", {31'd0, spacing_err}, 32'd1);
        min_gap = 16'd50;
        wait_clk(100);
        run_frame(16'h0000, 16, got);
        chk(spacing_err == 1, "R9 sticky", {31'd0, spacing_err}, 32'd1);

        // R4 pm rewritten away from normal, then back
        run_frame(16'h8000, 16, got);
        model_commit(16'h8000);
        chk(ctl_pm == 2'b00, "R4 pm cleared by write", {30'd0, ctl_pm}, 32'd0);
        run_frame(16'h8300, 16, got);
        model_commit(16'h8300);
        chk(ctl_pm == 2'b11, "R4 pm normal again", {30'd0, ctl_pm}, 32'd3);
        chk_ctl("R4 fields after pm write");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule